// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This block sits beside one DMA channel, either the send side or the receive side, and cuts the rate of interrupts it raises. Each completed packet arrives as a single-cycle pulse and is added to a pending count. The block raises a level interrupt once that count reaches a programmable threshold. A millisecond wait-bound timer starts with the first packet of a window. If it expires before the threshold is met, it raises the interrupt anyway, so a lone packet is never left waiting for long.

Software, or the surrounding channel logic, programs the threshold and the wait bound through two write strobes. The interrupt stays high until an acknowledge pulse arrives. That pulse clears the interrupt, empties the pending count and stops the timer. A packet that completes in the same cycle as the acknowledge opens the next window. The ports are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A parameter states which direction an instance serves: 1 for send, 2 for receive.

Top module: `pkt_irq_coalescer`

## Requirements
- R1: After reset `irq` is 0 and `pend_cnt` is 0. The threshold resets to 1 and the wait bound resets to 5 ms.
- R2: Each `pkt_done` pulse without `irq_ack` raises `pend_cnt` by one, visible after that clock edge.
- R3: `pend_cnt` saturates at 255. Further `pkt_done` pulses leave it at 255 and it never wraps to 0.
- R4: When `pend_cnt` is nonzero and at or above the threshold, `irq` goes to 1 on the next edge. A threshold of 0 acts as 1.
- R5: Once set, `irq` stays at 1 until `irq_ack`.
- R6: The wait timer starts on a `pkt_done` that arrives while `pend_cnt` is 0. It counts `ms_tick` pulses. On the edge after the tick count reaches the wait bound, `irq` goes to 1, and it does not rise earlier.
- R7: A wait bound of 0 turns the timer off. With it, only the threshold can raise `irq`.
- R8: `irq_ack` clears `irq` and `pend_cnt` on that edge and stops the timer. A `pkt_done` in the same cycle leaves `pend_cnt` at 1 and restarts the timer from zero.
- R9: `thr_we` loads `thr_wdata` and `wait_we` loads `wait_wdata` on the clock edge. If the new threshold is at or below a nonzero `pend_cnt`, `irq` rises on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle pulse per completed packet |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | New packet-count threshold |
| wait_we | input | 1 | Wait-bound write strobe |
| wait_wdata | input | 10 | New wait bound in milliseconds |
| irq | output | 1 | Level interrupt |
| pend_cnt | output | 8 | Packets pending in the current window |

## Verification
The hardest state to reach from the ports is the pending count pinned at 255. Getting there takes the threshold set to its maximum and the timer turned off, so that nothing fires or clears the count on the way up. Packets then keep arriving well past 255. The other narrow corner is an acknowledge and a packet in the same cycle. The bench drives both pulses on one edge, then proves the timer restarted by counting exactly the wait bound of ticks before the interrupt returns.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_CNT_W    = 8;
  localparam int unsigned PIC_WAIT_W   = 10;
  localparam int unsigned PIC_THR_RST  = 1;
  localparam int unsigned PIC_WAIT_RST = 5;

  typedef enum logic [1:0] {
    DIR_SEND = 2'd1,
    DIR_RECV = 2'd2
  } pic_dir_e;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WAIT_W   = 10,
  parameter int unsigned THR_RST  = 1,
  parameter int unsigned WAIT_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [CNT_W-1:0]  thr_wdata,
  input  logic              wait_we,
  input  logic [WAIT_W-1:0] wait_wdata,
  output logic [CNT_W-1:0]  thr_q,
  output logic [WAIT_W-1:0] wait_q
);
  localparam logic [CNT_W-1:0]  THR_INIT  = CNT_W'(THR_RST);
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(WAIT_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q  <= THR_INIT;
      wait_q <= WAIT_INIT;
    end else begin
      if (thr_we)  thr_q  <= thr_wdata;
      if (wait_we) wait_q <= wait_wdata;
    end
  end

  // R9: a write strobe lands its data on the edge
  p_thr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> thr_q == $past(thr_wdata));
endmodule

// File: rtl/pic_pend_counter.sv
module pic_pend_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_done,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (irq_ack) begin
      cnt_q <= pkt_done ? CNT_ONE : '0;
    end else if (pkt_done && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  // R3: a full counter stays full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !irq_ack) |=> cnt_q == CNT_MAX);

  // R2: one step per packet below saturation
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !irq_ack && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);

  // R8: acknowledge restarts the window
  p_ack_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> cnt_q == ($past(pkt_done) ? CNT_ONE : '0));
endmodule

// File: rtl/pic_wait_timer.sv
module pic_wait_timer #(
  parameter int unsigned WAIT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic              pend_zero,
  input  logic              irq_ack,
  input  logic              ms_tick,
  input  logic [WAIT_W-1:0] wait_q,
  output logic              expire
);
  localparam logic [WAIT_W-1:0] MS_MAX = {WAIT_W{1'b1}};
  localparam logic [WAIT_W-1:0] MS_ONE = WAIT_W'(1);

  logic              run_q;
  logic [WAIT_W-1:0] ms_q;
  logic              start;

  assign start  = pkt_done && pend_zero;
  assign expire = run_q && (wait_q != '0) && (ms_q >= wait_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ms_q  <= '0;
    end else if (irq_ack) begin
      run_q <= pkt_done;
      ms_q  <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      ms_q  <= '0;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q && ms_tick && ms_q != MS_MAX) begin
      ms_q <= ms_q + MS_ONE;
    end
  end

  // R6: a window's first packet starts the timer from zero
  p_timer_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !irq_ack) |=> (run_q && ms_q == '0));

  // R7: a zero bound never expires
  p_wait_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q == '0) |-> !expire);
endmodule

// File: rtl/pkt_irq_coalescer.sv
module pkt_irq_coalescer
  import pic_pkg::*;
#(
  parameter int unsigned CNT_W    = PIC_CNT_W,
  parameter int unsigned WAIT_W   = PIC_WAIT_W,
  parameter int unsigned THR_RST  = PIC_THR_RST,
  parameter int unsigned WAIT_RST = PIC_WAIT_RST,
  parameter int unsigned CHAN_DIR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic              ms_tick,
  input  logic              irq_ack,
  input  logic              thr_we,
  input  logic [CNT_W-1:0]  thr_wdata,
  input  logic              wait_we,
  input  logic [WAIT_W-1:0] wait_wdata,
  output logic              irq,
  output logic [CNT_W-1:0]  pend_cnt
);
  localparam pic_dir_e DIR = pic_dir_e'(CHAN_DIR[1:0]);

  generate
    if (DIR != DIR_SEND && DIR != DIR_RECV) begin : g_bad_dir
      $error("CHAN_DIR must be 1 (send) or 2 (receive)");
    end
  endgenerate

  logic [CNT_W-1:0]  thr_q;
  logic [WAIT_W-1:0] wait_q;
  logic              pend_zero;
  logic              expire;
  logic              thr_hit;
  logic              irq_q;

  pic_cfg_regs #(
    .CNT_W(CNT_W), .WAIT_W(WAIT_W), .THR_RST(THR_RST), .WAIT_RST(WAIT_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .wait_we(wait_we), .wait_wdata(wait_wdata),
    .thr_q(thr_q), .wait_q(wait_q)
  );

  pic_pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .pkt_done(pkt_done), .irq_ack(irq_ack),
    .cnt_q(pend_cnt), .cnt_zero(pend_zero)
  );

  pic_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .pkt_done(pkt_done), .pend_zero(pend_zero), .irq_ack(irq_ack),
    .ms_tick(ms_tick), .wait_q(wait_q), .expire(expire)
  );

  assign thr_hit = !pend_zero && (pend_cnt >= thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (irq_ack)  irq_q <= 1'b0;
    else if (thr_hit || expire) irq_q <= 1'b1;
  end

  assign irq = irq_q;

  // R5: the interrupt holds until acknowledged
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R8: acknowledge drops the interrupt
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  // R4: pending at or above threshold raises the interrupt
  p_thr_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt != '0 && pend_cnt >= thr_q && !irq_ack) |=> irq);
endmodule

// File: tb/sim_pkt_irq_coalescer.sv
`timescale 1ns/1ps
module sim_pkt_irq_coalescer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_done = 1'b0, ms_tick = 1'b0, irq_ack = 1'b0;
  logic       thr_we = 1'b0, wait_we = 1'b0;
  logic [7:0] thr_wdata = '0;
  logic [9:0] wait_wdata = '0;
  logic       irq;
  logic [7:0] pend_cnt;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pkt_irq_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .ms_tick(ms_tick),
    .irq_ack(irq_ack), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .wait_we(wait_we), .wait_wdata(wait_wdata), .irq(irq), .pend_cnt(pend_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, sample just after the edge
  task automatic step(input logic pd, input logic tk, input logic ak);
    @(negedge clk);
    pkt_done = pd; ms_tick = tk; irq_ack = ak;
    @(posedge clk); #1;
    pkt_done = 0; ms_tick = 0; irq_ack = 0;
  endtask

  task automatic wr_thr(input int v);
    @(negedge clk); thr_we = 1; thr_wdata = 8'(v);
    @(posedge clk); #1; thr_we = 0;
  endtask

  task automatic wr_wait(input int v);
    @(negedge clk); wait_we = 1; wait_wdata = 10'(v);
    @(posedge clk); #1; wait_we = 0;
  endtask

  task automatic ack();
    step(0, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 irq after reset", int'(irq), 0);
    check("R1 pend after reset", int'(pend_cnt), 0);
    step(1, 0, 0);
    check("R2 pend after one packet", int'(pend_cnt), 1);
    check("R1 default threshold 1 not yet", int'(irq), 0);
    step(0, 0, 0);
    check("R1 default threshold 1 fires", int'(irq), 1);
    step(0, 0, 0);
    check("R5 irq holds", int'(irq), 1);
    ack();
    check("R8 irq cleared", int'(irq), 0);
    check("R8 pend cleared", int'(pend_cnt), 0);
  endtask

  task automatic t_default_wait();
    wr_thr(50);
    step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    step(0, 1, 0);
    check("R1 default wait 5 not early", int'(irq), 0);
    step(0, 0, 0);
    check("R6 wait expiry fires", int'(irq), 1);
    ack();
  endtask

  task automatic t_threshold();
    wr_thr(3); wr_wait(0);
    step(1, 0, 0); step(1, 0, 0);
    step(0, 0, 0);
    check("R4 below threshold", int'(irq), 0);
    step(1, 0, 0);
    check("R2 pend three", int'(pend_cnt), 3);
    check("R4 not same edge", int'(irq), 0);
    step(0, 0, 0);
    check("R4 threshold fires", int'(irq), 1);
    ack();
    wr_thr(0);
    step(1, 0, 0); step(0, 0, 0);
    check("R4 threshold 0 acts as 1", int'(irq), 1);
    ack();
  endtask

  task automatic t_wait_off();
    wr_thr(10); wr_wait(0);
    step(1, 0, 0); step(1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    check("R7 timer off, no irq", int'(irq), 0);
    check("R7 pend kept", int'(pend_cnt), 2);
    ack();
  endtask

  task automatic t_ack_and_pkt();
    wr_thr(10); wr_wait(3);
    step(1, 0, 0);
    step(0, 1, 0); step(0, 1, 0);
    step(1, 0, 1);
    check("R8 same-cycle packet counted", int'(pend_cnt), 1);
    check("R8 irq low after ack", int'(irq), 0);
    step(0, 1, 0); step(0, 1, 0);
    step(0, 0, 0);
    check("R8 timer restarted from zero", int'(irq), 0);
    step(0, 1, 0);
    step(0, 0, 0);
    check("R6 fires after bound ticks", int'(irq), 1);
    ack();
  endtask

  task automatic t_thr_write();
    wr_thr(20); wr_wait(0);
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    check("R9 no irq at threshold 20", int'(irq), 0);
    wr_thr(4);
    check("R9 not on write edge", int'(irq), 0);
    step(0, 0, 0);
    check("R9 irq after lowering threshold", int'(irq), 1);
    ack();
  endtask

  task automatic t_saturate();
    wr_thr(255); wr_wait(0);
    for (int i = 0; i < 254; i++) step(1, 0, 0);
    check("R3 pend 254", int'(pend_cnt), 254);
    check("R3 no irq at 254", int'(irq), 0);
    for (int i = 0; i < 46; i++) step(1, 0, 0);
    check("R3 pend saturates at 255", int'(pend_cnt), 255);
    check("R4 irq at 255", int'(irq), 1);
    ack();
    check("R8 pend cleared after saturation", int'(pend_cnt), 0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_default_wait();
    t_threshold();
    t_wait_off();
    t_ack_and_pkt();
    t_thr_write();
    t_saturate();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule